// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block is the issue gate of a single-issue pipeline that feeds several functional units of different latency. Each cycle the decode stage presents the instruction at the head of the queue: the class of unit it needs, an optional destination register, and up to two source registers with flags that say whether each source is read. The scoreboard answers in the same cycle. Either the instruction dispatches now, or it stalls, and a code gives the reason.

Two pieces of state make the decision. The first is one busy flag per functional unit. The second is one write-pending flag per architectural register. Dispatching an instruction marks its unit busy and its destination pending. A writeback notification clears the pending flag of the written register. A unit-free pulse, one bit per unit, clears busy flags. Units capture their operands at dispatch and dispatch never reorders, so an instruction cannot overwrite a register before an older instruction has read it. For that reason no source register is recorded. A second write to a register that already has a write outstanding holds the head instead, so completions that arrive out of order never collide on a register.

The upstream stage must keep the head instruction stable until the cycle in which `issue_valid` is high. This is what keeps dispatch in program order.

Top module: `issue_scoreboard`

## Requirements
- R1: Once reset is released, no unit is busy and no register is pending, so a valid head instruction of any class, with any registers, dispatches in its first cycle with stall code 0.
- R2: While the busy flag of the requested unit is set, the head stalls with stall code 1. A pulse on the unit's bit of `unit_free` clears the flag, and the head may dispatch in the following cycle but not in the pulse cycle. Unit classes are 0 = integer/memory, 1 = add, 2 = multiply, 3 = divide.
- R3: A head that reads a register, on either source that is flagged as used, whose write is pending stalls with stall code 2.
- R4: A head whose destination register has a write pending stalls with stall code 3.
- R5: When several hazards apply at once, the stall code reports the unit conflict first, then the read hazard, then the write-after-write hazard.
- R6: A dispatch marks the chosen unit busy and the destination register pending, and both take effect from the next cycle.
- R7: A writeback of register r clears its pending flag. A head stalled on r may dispatch in the cycle after the writeback cycle, and not in the writeback cycle itself.
- R8: If a writeback of register r and a dispatch targeting r fall in the same cycle, r stays pending.
- R9: A source whose used flag is 0 never causes a stall. Register 0 is hardwired to zero: it is never pending, never causes a stall, and a write to it marks nothing.
- R10: `issue_valid` is high only when `head_valid` is high. With no valid head the stall code is 0. A stalled head changes neither busy nor pending state.
- R11: Hazards on a register that an in-flight instruction only reads are not checked. A head may write a register that an issued but unfinished instruction reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| head_valid | input | 1 | A decoded instruction is present at the head |
| head_unit | input | 2 | Unit class needed (0 int/mem, 1 add, 2 mul, 3 div) |
| head_wr | input | 1 | The instruction writes a destination register |
| head_dst | input | 5 | Destination register |
| head_src_a | input | 5 | First source register |
| head_use_a | input | 1 | First source is read |
| head_src_b | input | 5 | Second source register |
| head_use_b | input | 1 | Second source is read |
| wb_we | input | 1 | Writeback of a register this cycle |
| wb_ws | input | 5 | Register being written back |
| unit_free | input | 4 | One bit per unit: that unit becomes free |
| issue_valid | output | 1 | The head instruction dispatches this cycle |
| stall_code | output | 2 | 0 none, 1 unit busy, 2 read hazard, 3 write-after-write |

## Verification
Busy and pending state cannot be read directly. A busy or pending flag that is wrongly set shows up as a stall the next time the head names that unit or register, with the matching code. A flag that is wrongly clear shows up as a dispatch where the code should have been 1, 2 or 3. Each state update becomes visible exactly one cycle after it is caused, so every scenario checks in the cycle that follows its stimulus. This includes the cases where a clear and a set fall in the same cycle, or where a release and a check do.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    STALL_NONE = 2'd0,
    STALL_UNIT = 2'd1,
    STALL_RAW  = 2'd2,
    STALL_WAW  = 2'd3
  } stall_e;

  localparam int UNIT_INTMEM = 0;
  localparam int UNIT_ADD    = 1;
  localparam int UNIT_MUL    = 2;
  localparam int UNIT_DIV    = 3;

endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sb_pending.sv
module sb_pending #(
  parameter int NUM_REGS  = 32,
  parameter bit ZERO_HARD = 1'b1,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [REG_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] pend
);

  // One flop per register, each with its own written-out enable.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (ZERO_HARD && r == 0) begin : g_zero
      assign pend[r] = 1'b0;
    end else begin : g_live
      logic set_hit;
      logic clr_hit;
      logic flag_en;
      logic flag_d;
      logic flag_q;

      always_comb begin
        set_hit = set_en && (set_idx == REG_W'(r));
        clr_hit = clr_en && (clr_idx == REG_W'(r));
        flag_en = set_hit || clr_hit;
        flag_d  = set_hit;            // set beats clear in the same cycle
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= 1'b0;
        end else if (flag_en) begin
          flag_q <= flag_d;
        end
      end

      assign pend[r] = flag_q;
    end
  end

endmodule

// File: rtl/sb_busy.sv
module sb_busy #(
  parameter int NUM_UNITS = 4,
  localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_en,
  input  logic [UNIT_W-1:0]    take_idx,
  input  logic [NUM_UNITS-1:0] free_mask,
  output logic [NUM_UNITS-1:0] busy
);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic take_hit;
    logic bit_en;
    logic bit_d;
    logic bit_q;

    always_comb begin
      take_hit = take_en && (take_idx == UNIT_W'(u));
      bit_en   = take_hit || free_mask[u];
      bit_d    = take_hit;              // a new dispatch beats a free pulse
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign busy[u] = bit_q;
  end

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
  import sb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  parameter bit ZERO_HARD = 1'b1,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
  input  logic                 head_valid,
  input  logic [UNIT_W-1:0]    head_unit,
  input  logic                 head_wr,
  input  logic [REG_W-1:0]     head_dst,
  input  logic [REG_W-1:0]     head_src_a,
  input  logic                 head_use_a,
  input  logic [REG_W-1:0]     head_src_b,
  input  logic                 head_use_b,
  input  logic [NUM_REGS-1:0]  pend,
  input  logic [NUM_UNITS-1:0] busy,
  output logic                 dispatch,
  output logic                 dst_live,
  output stall_e               reason
);

  logic live_a;
  logic live_b;
  logic hz_unit;
  logic hz_raw;
  logic hz_waw;

  function automatic logic is_zero(input logic [REG_W-1:0] idx);
    return ZERO_HARD && (idx == '0);
  endfunction

  always_comb begin
    live_a   = head_use_a && !is_zero(head_src_a);
    live_b   = head_use_b && !is_zero(head_src_b);
    dst_live = head_wr && !is_zero(head_dst);

    hz_unit  = busy[head_unit];
    hz_raw   = (live_a && pend[head_src_a]) || (live_b && pend[head_src_b]);
    hz_waw   = dst_live && pend[head_dst];

    reason   = STALL_NONE;
    if (head_valid) begin
      if (hz_unit) begin
        reason = STALL_UNIT;
      end else if (hz_raw) begin
        reason = STALL_RAW;
      end else if (hz_waw) begin
        reason = STALL_WAW;
      end
    end
    dispatch = head_valid && (reason == STALL_NONE);
  end

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  parameter bit ZERO_HARD = 1'b1,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 head_valid,
  input  logic [UNIT_W-1:0]    head_unit,
  input  logic                 head_wr,
  input  logic [REG_W-1:0]     head_dst,
  input  logic [REG_W-1:0]     head_src_a,
  input  logic                 head_use_a,
  input  logic [REG_W-1:0]     head_src_b,
  input  logic                 head_use_b,
  input  logic                 wb_we,
  input  logic [REG_W-1:0]     wb_ws,
  input  logic [NUM_UNITS-1:0] unit_free,
  output logic                 issue_valid,
  output logic [1:0]           stall_code
);

  logic                 rst_core_n;
  logic [NUM_REGS-1:0]  pend;
  logic [NUM_UNITS-1:0] busy;
  logic                 dispatch;
  logic                 dst_live;
  stall_e               reason;

  sb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sb_hazard #(
    .NUM_REGS  (NUM_REGS),
    .NUM_UNITS (NUM_UNITS),
    .ZERO_HARD (ZERO_HARD)
  ) u_hazard (
    .head_valid (head_valid),
    .head_unit  (head_unit),
    .head_wr    (head_wr),
    .head_dst   (head_dst),
    .head_src_a (head_src_a),
    .head_use_a (head_use_a),
    .head_src_b (head_src_b),
    .head_use_b (head_use_b),
    .pend       (pend),
    .busy       (busy),
    .dispatch   (dispatch),
    .dst_live   (dst_live),
    .reason     (reason)
  );

  sb_pending #(
    .NUM_REGS  (NUM_REGS),
    .ZERO_HARD (ZERO_HARD)
  ) u_pending (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_en  (dispatch && dst_live),
    .set_idx (head_dst),
    .clr_en  (wb_we),
    .clr_idx (wb_ws),
    .pend    (pend)
  );

  sb_busy #(
    .NUM_UNITS (NUM_UNITS)
  ) u_busy (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .take_en   (dispatch),
    .take_idx  (head_unit),
    .free_mask (unit_free),
    .busy      (busy)
  );

  assign issue_valid = dispatch;
  assign stall_code  = reason;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  parameter bit ZERO_HARD = 1'b1,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 head_valid,
  input logic [UNIT_W-1:0]    head_unit,
  input logic                 head_wr,
  input logic [REG_W-1:0]     head_dst,
  input logic [REG_W-1:0]     head_src_a,
  input logic                 head_use_a,
  input logic                 issue_valid,
  input logic [1:0]           stall_code
);

  logic tgt_live;
  assign tgt_live = head_wr && !(ZERO_HARD && head_dst == '0);

  AST_UNIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !(issue_valid && head_unit == $past(head_unit))); // R2

  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && tgt_live) |=>
      !(issue_valid && head_use_a && head_src_a == $past(head_dst))); // R3

  AST_DOUBLE_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && tgt_live) |=>
      !(issue_valid && head_wr && head_dst == $past(head_dst))); // R4

  AST_NO_HEAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> (!issue_valid && stall_code == 2'd0)); // R10

  AST_STALL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_code != 2'd0) |-> (head_valid && !issue_valid)); // R10

endmodule

bind issue_scoreboard sb_checker #(
  .NUM_REGS  (NUM_REGS),
  .NUM_UNITS (NUM_UNITS),
  .ZERO_HARD (ZERO_HARD)
) u_sb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .head_valid  (head_valid),
  .head_unit   (head_unit),
  .head_wr     (head_wr),
  .head_dst    (head_dst),
  .head_src_a  (head_src_a),
  .head_use_a  (head_use_a),
  .issue_valid (issue_valid),
  .stall_code  (stall_code)
);

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;

  localparam int U_INT = 0;
  localparam int U_ADD = 1;
  localparam int U_MUL = 2;
  localparam int U_DIV = 3;
  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_UNIT = 2'd1;
  localparam logic [1:0] C_RAW  = 2'd2;
  localparam logic [1:0] C_WAW  = 2'd3;

  logic       clk;
  logic       rst_n;
  logic       head_valid;
  logic [1:0] head_unit;
  logic       head_wr;
  logic [4:0] head_dst;
  logic [4:0] head_src_a;
  logic       head_use_a;
  logic [4:0] head_src_b;
  logic       head_use_b;
  logic       wb_we;
  logic [4:0] wb_ws;
  logic [3:0] unit_free;
  logic       issue_valid;
  logic [1:0] stall_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  issue_scoreboard u_issue_scoreboard (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .head_unit  (head_unit),
    .head_wr    (head_wr),
    .head_dst   (head_dst),
    .head_src_a (head_src_a),
    .head_use_a (head_use_a),
    .head_src_b (head_src_b),
    .head_use_b (head_use_b),
    .wb_we      (wb_we),
    .wb_ws      (wb_ws),
    .unit_free  (unit_free),
    .issue_valid(issue_valid),
    .stall_code (stall_code)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wb_we     = 1'b0;
    unit_free = '0;
  endtask

  task automatic present(input int unit, input bit wr, input int dst,
                         input int sa, input bit ua, input int sb, input bit ub);
    head_valid = 1'b1;
    head_unit  = 2'(unit);
    head_wr    = wr;
    head_dst   = 5'(dst);
    head_src_a = 5'(sa);
    head_use_a = ua;
    head_src_b = 5'(sb);
    head_use_b = ub;
  endtask

  task automatic idle();
    head_valid = 1'b0;
  endtask

  task automatic expect_out(input logic eiv, input logic [1:0] ecode, input string tag);
    #1;
    checks++;
    if (issue_valid !== eiv || stall_code !== ecode) begin
      errors++;
      $display("FAIL %s: issue_valid=%0b stall_code=%0d expected issue_valid=%0b stall_code=%0d",
               tag, issue_valid, stall_code, eiv, ecode);
    end
  endtask

  task automatic retire(input int reg_idx, input logic [3:0] mask);
    idle();
    wb_we     = 1'b1;
    wb_ws     = 5'(reg_idx);
    unit_free = mask;
    tick();
  endtask

  task automatic t_reset();
    present(U_INT, 1, 1, 2, 1, 3, 1);
    expect_out(1'b1, C_NONE, "R1 first dispatch after reset");
    tick();
    retire(1, 4'b0001);
  endtask

  task automatic t_unit_busy();
    present(U_MUL, 1, 4, 0, 0, 0, 0);
    expect_out(1'b1, C_NONE, "R2 mul dispatch");
    tick();
    present(U_MUL, 1, 5, 0, 0, 0, 0);
    unit_free = 4'b0100;
    expect_out(1'b0, C_UNIT, "R2 R6 busy mul stalls in free cycle");
    tick();
    expect_out(1'b1, C_NONE, "R2 mul dispatch after free");
    tick();
    retire(4, 4'b0100);
    retire(5, 4'b0000);
  endtask

  task automatic t_read_hazard();
    present(U_ADD, 1, 7, 0, 0, 0, 0);
    expect_out(1'b1, C_NONE, "R3 producer dispatch");
    tick();
    present(U_INT, 1, 8, 3, 1, 7, 1);
    unit_free = 4'b0010;
    wb_we = 1'b1;
    wb_ws = 5'd7;
    expect_out(1'b0, C_RAW, "R3 R6 R7 reader stalled in writeback cycle");
    tick();
    expect_out(1'b1, C_NONE, "R7 reader dispatches after writeback");
    tick();
    retire(8, 4'b0001);
  endtask

  task automatic t_double_write();
    present(U_DIV, 1, 9, 0, 0, 0, 0);
    expect_out(1'b1, C_NONE, "R4 first writer");
    tick();
    present(U_ADD, 1, 9, 0, 0, 0, 0);
    expect_out(1'b0, C_WAW, "R4 second writer stalled");
    wb_we = 1'b1;
    wb_ws = 5'd9;
    unit_free = 4'b1000;
    tick();
    expect_out(1'b1, C_NONE, "R4 second writer after writeback");
    tick();
    retire(9, 4'b0010);
    present(U_INT, 1, 9, 0, 0, 0, 0);
    wb_we = 1'b1;
    wb_ws = 5'd9;
    expect_out(1'b1, C_NONE, "R8 dispatch with same-cycle writeback");
    tick();
    present(U_ADD, 1, 9, 0, 0, 0, 0);
    expect_out(1'b0, C_WAW, "R8 set wins over clear");
    tick();
    retire(9, 4'b0001);
  endtask

  task automatic t_priority();
    present(U_DIV, 1, 10, 0, 0, 0, 0);
    expect_out(1'b1, C_NONE, "R5 setup");
    tick();
    present(U_DIV, 1, 10, 10, 1, 0, 0);
    expect_out(1'b0, C_UNIT, "R5 unit over read over write");
    tick();
    present(U_ADD, 1, 10, 0, 0, 10, 1);
    expect_out(1'b0, C_RAW, "R5 read over write");
    tick();
    present(U_ADD, 1, 10, 0, 0, 0, 0);
    expect_out(1'b0, C_WAW, "R5 write only");
    tick();
    retire(10, 4'b1000);
  endtask

  task automatic t_ignored_sources();
    present(U_MUL, 1, 11, 0, 0, 0, 0);
    expect_out(1'b1, C_NONE, "R9 setup");
    tick();
    present(U_ADD, 1, 12, 11, 0, 11, 0);
    expect_out(1'b1, C_NONE, "R9 unused sources ignored");
    tick();
    present(U_INT, 1, 0, 0, 1, 0, 1);
    expect_out(1'b1, C_NONE, "R9 write to r0");
    tick();
    present(U_DIV, 1, 0, 0, 1, 0, 0);
    expect_out(1'b1, C_NONE, "R9 r0 never pending");
    tick();
    retire(11, 4'b1111);
    retire(12, 4'b0000);
  endtask

  task automatic t_read_only_inflight();
    present(U_MUL, 1, 13, 14, 1, 0, 0);
    expect_out(1'b1, C_NONE, "R11 setup");
    tick();
    present(U_ADD, 1, 14, 0, 0, 0, 0);
    expect_out(1'b1, C_NONE, "R11 overwrite of in-flight source");
    tick();
    retire(13, 4'b0110);
    retire(14, 4'b0000);
  endtask

  task automatic t_in_order();
    idle();
    expect_out(1'b0, C_NONE, "R10 no head");
    tick();
    present(U_ADD, 1, 15, 0, 0, 0, 0);
    expect_out(1'b1, C_NONE, "R10 setup");
    tick();
    present(U_ADD, 1, 16, 0, 0, 0, 0);
    expect_out(1'b0, C_UNIT, "R10 stall cycle one");
    tick();
    expect_out(1'b0, C_UNIT, "R10 stall cycle two");
    tick();
    present(U_INT, 1, 16, 16, 1, 16, 1);
    expect_out(1'b1, C_NONE, "R10 stalled head marked nothing");
    tick();
    retire(15, 4'b0011);
    retire(16, 4'b0000);
  endtask

  initial begin
    rst_n = 1'b0;
    head_valid = 1'b0;
    head_unit = '0;
    head_wr = 1'b0;
    head_dst = '0;
    head_src_a = '0;
    head_use_a = 1'b0;
    head_src_b = '0;
    head_use_b = 1'b0;
    wb_we = 1'b0;
    wb_ws = '0;
    unit_free = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unit_busy();
    t_read_hazard();
    t_double_write();
    t_priority();
    t_ignored_sources();
    t_read_only_inflight();
    t_in_order();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule